// File: doc/BRIEF.md
# Filtered sticky press flag

This block watches a raw, asynchronous, active-high pushbutton line and raises a flag once it has seen a genuine press. From then on the flag stays high. The button is never used as a clock and no level-sensitive storage is inferred. The raw line first crosses into a fast free-running clock domain through a two-flop synchronizer. A qualification counter then has to see the synchronized level stay high for a parameterised number of consecutive cycles before the flag is allowed to set. Glitches, single edges and short bursts are therefore discarded.

The flag can only be cleared by the asynchronous active-low reset. Reset also clears the synchronizer and the counter, so any press that was partly counted is forgotten. A companion output pulses for exactly one cycle on the edge where the flag goes from 0 to 1, for logic that wants an event rather than a level. There is no data stream here, so all pins are plain control and status signals with no handshake.

Top module: `sticky_press_flag`

## Requirements
- R1: While reset is low, and in the cycles after it is released with the button low, both `flag_o` and `set_pulse_o` read 0.
- R2: With `QUAL_CYCLES` = N, a button held high from just after a rising edge makes `flag_o` read 1 exactly N+2 rising edges later (two edges of synchronizer latency, N of qualification). This also holds when the button is already high as reset is released.
- R3: A press that covers fewer than N consecutive rising edges never sets the flag. A press covering N or more edges always sets it.
- R4: Any rising edge at which the synchronized level is low restarts qualification from zero. Two runs of N-1 high edges separated by one low edge do not set the flag.
- R5: Once `flag_o` is 1 it stays 1 whatever the button does, until reset.
- R6: `set_pulse_o` is high for exactly one cycle per set event. It is high during the same cycle in which `flag_o` first reads 1, and it is low at all other times.
- R7: Pulling `rst_n` low clears `flag_o` at once, without waiting for a clock edge. While reset is held, a high button cannot set the flag.
- R8: A high glitch on the button that starts and ends between two rising edges has no effect on the flag.
- R9: Reset discards partial qualification. After an assert/release of reset, a further N-1 high edges do not set the flag, even if N-1 high edges were counted before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears synchronizer, counter and flag |
| btn_in | input | 1 | Raw asynchronous pushbutton line, high when pressed |
| flag_o | output | 1 | Sticky flag, 1 after a qualified press |
| set_pulse_o | output | 1 | One-cycle strobe in the first cycle the flag reads 1 |

## Verification
The hardest state to reach from the pins is a qualification counter that is one count short of firing, at the moment reset arrives (R9). The flag output shows nothing until the count completes, so the bench computes from the known two-edge synchronizer latency how many edges the button must be held for the counter to sit at N-1. It applies reset at exactly that point, releases it, and then supplies N-1 more high edges; a stale count would set the flag. The gap case (R4) and the between-edge glitch (R8) are built the same way, by placing button transitions at negedges or in the middle of a low phase.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;
  // Fixed synchronizer depth demanded by the crossing rule.
  localparam int SYNC_DEPTH = 2;

  // Bits needed to hold values 0..n.
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/spf_sync.sv
`timescale 1ns/1ps
module spf_sync #(
  parameter int STAGES = spf_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/spf_qual.sv
`timescale 1ns/1ps
module spf_qual #(
  parameter int QUAL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic hold,
  output logic hit
);
  localparam int CW = spf_pkg::cnt_bits(QUAL_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] run_cnt = '0;

  // run_cnt = number of earlier consecutive high edges, capped at LAST
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_cnt <= '0;
    else if (hold)            run_cnt <= run_cnt;
    else if (!lvl)            run_cnt <= '0;
    else if (run_cnt != LAST) run_cnt <= run_cnt + 1'b1;
  end

  assign hit = lvl && !hold && (run_cnt == LAST);
endmodule

// File: rtl/spf_flag.sv
`timescale 1ns/1ps
module spf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  output logic flag,
  output logic pulse
);
  logic flag_q  = 1'b0;
  logic pulse_q = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_q | set_req;
      pulse_q <= set_req & ~flag_q;
    end
  end

  assign flag  = flag_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/sticky_press_flag.sv
`timescale 1ns/1ps
module sticky_press_flag #(
  parameter int QUAL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_in,
  output logic flag_o,
  output logic set_pulse_o
);
  logic sync_lvl;
  logic qual_hit;
  logic flag_int;

  spf_sync #(.STAGES(spf_pkg::SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(btn_in),
    .q_sync (sync_lvl)
  );

  spf_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (sync_lvl),
    .hold (flag_int),
    .hit  (qual_hit)
  );

  spf_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(qual_hit),
    .flag   (flag_int),
    .pulse  (set_pulse_o)
  );

  assign flag_o = flag_int;
endmodule

// File: rtl/spf_chk.sv
`timescale 1ns/1ps
module spf_chk #(
  parameter int QUAL_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sync_lvl,
  input logic flag_o,
  input logic set_pulse_o
);
  localparam int RW = spf_pkg::cnt_bits(QUAL_CYCLES);
  localparam logic [RW-1:0] CAP = RW'(QUAL_CYCLES);

  // consecutive synchronized-high edges seen, saturating at N
  logic [RW-1:0] hi_run = '0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_run <= '0;
    else if (!sync_lvl)  hi_run <= '0;
    else if (hi_run != CAP) hi_run <= hi_run + 1'b1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) !rst_n |-> (!flag_o && !set_pulse_o));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) flag_o |=> flag_o);

  // R3
  qualified_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> (hi_run == CAP));

  // R6
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> set_pulse_o);

  // R6
  pulse_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse_o |-> (flag_o && !$past(flag_o)));

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse_o |=> !set_pulse_o);
endmodule

bind sticky_press_flag spf_chk #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_lvl   (sync_lvl),
  .flag_o     (flag_o),
  .set_pulse_o(set_pulse_o)
);

// File: tb/sticky_press_flag_tb.sv
`timescale 1ns/1ps
module sticky_press_flag_tb;
  localparam int Q = 4;
  localparam int NV = 5;
  // stimulus table: high-edge count and whether it must set the flag
  localparam int  VEC_HOLD [NV] = '{1, Q-1, Q, Q+1, 5*Q};
  localparam bit  VEC_SET  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn = 1'b0;
  logic flag;
  logic pulse;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sticky_press_flag #(.QUAL_CYCLES(Q)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .btn_in     (btn),
    .flag_o     (flag),
    .set_pulse_o(pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    btn = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // btn high across 'hold' rising edges; report first edge index with flag high
  task automatic press(input int hold, output int lat, output int pulse_at_rise,
                       output int pulses);
    lat = 0;
    pulse_at_rise = 0;
    pulses = 0;
    btn = 1'b1;
    for (int k = 1; k <= hold + Q + 10; k++) begin
      @(negedge clk);
      if (flag && lat == 0) begin
        lat = k;
        pulse_at_rise = int'(pulse);
      end
      if (pulse) pulses++;
      if (k == hold) btn = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lat, par, np, cnt_hi;
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 flag in reset", int'(flag), 0);
    check("R1 pulse in reset", int'(pulse), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 flag after release", int'(flag), 0);

    // table walk: R2, R3, R6
    for (int v = 0; v < NV; v++) begin
      do_reset();
      press(VEC_HOLD[v], lat, par, np);
      check("R3 flag after press", int'(flag), int'(VEC_SET[v]));
      if (VEC_SET[v]) begin
        check("R2 latency", lat, Q + 2);
        check("R6 pulse at rise", par, 1);
        check("R6 pulse count", np, 1);
      end else begin
        check("R6 no pulse", np, 0);
      end
    end

    // R8 glitch between edges
    do_reset();
    btn = 1'b1;
    #1 btn = 1'b0;
    repeat (Q + 6) @(negedge clk);
    check("R8 glitch ignored", int'(flag), 0);

    // R4 low gap restarts qualification
    do_reset();
    btn = 1'b1;
    repeat (Q - 1) @(negedge clk);
    btn = 1'b0;
    @(negedge clk);
    btn = 1'b1;
    repeat (Q - 1) @(negedge clk);
    btn = 1'b0;
    repeat (Q + 6) @(negedge clk);
    check("R4 gap restarts", int'(flag), 0);

    // R5 sticky after set, input toggling
    do_reset();
    press(Q + 2, lat, par, np);
    cnt_hi = 0;
    np = 0;
    for (int k = 0; k < 24; k++) begin
      btn = (k % 3 == 0);
      @(negedge clk);
      if (flag) cnt_hi++;
      if (pulse) np++;
    end
    check("R5 flag held", cnt_hi, 24);
    check("R6 no repeat pulse", np, 0);

    // R7 async reset clears mid-cycle, priority over set
    btn = 1'b1;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R7 async clear", int'(flag), 0);
    repeat (Q + 4) @(negedge clk);
    check("R7 reset priority", int'(flag), 0);
    rst_n = 1'b1;
    lat = 0;
    for (int k = 1; k <= Q + 8; k++) begin
      @(negedge clk);
      if (flag && lat == 0) lat = k;
    end
    check("R2 latency from reset release", lat, Q + 2);

    // R9 reset discards partial count (counter at N-1 after Q+1 edges)
    do_reset();
    btn = 1'b1;
    repeat (Q + 1) @(negedge clk);
    rst_n = 1'b0;
    btn = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    btn = 1'b1;
    repeat (Q - 1) @(negedge clk);
    btn = 1'b0;
    repeat (Q + 6) @(negedge clk);
    check("R9 partial count discarded", int'(flag), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule